// File: doc/BRIEF.md
# Narrow Read Port with Byte Reordering

This block is the read-side front end of a 36-bit wide queue that feeds a narrower consumer. Each stored entry is a long word made of four 9-bit bytes. The consumer can take an entry as one long word, as two 18-bit halves or as four single bytes. Before the entry is split, one of four byte permutations is applied, and an endianness input decides which piece comes out first and which output lanes carry it.

The block looks at the head entry of the storage and the storage's non-empty flag. It raises a one-cycle pop request on the read that consumes the final piece of an entry. The read data output and the data-available flag are registered. The available flag drops for one cycle after an entry is finished, and the storage updates its head during that cycle. One size code does not read the queue at all: it puts a separate mailbox word on the output instead. The permutation, endianness and size seen on the first piece of an entry stay in force until its last piece has been read.

Top module: `bmr_read_port`

## Requirements
- R1: While reset is asserted (`rst_n` low), `rd_data` is all zeros and `data_avail` is 0.
- R2: Bytes are numbered from the top of the word: A = bits 35-27, B = 26-18, C = 17-9, D = 8-0. `swap_mode` selects the permuted word: 00 gives ABCD, 01 gives DCBA, 10 gives CDAB, 11 gives BADC.
- R3: With `size_code` = 10 (byte), an entry takes four reads. For read number i (0 to 3), big-endian (`big_endian` = 1) places permuted byte i (counted from the top) on lanes 35-27. Little-endian places permuted byte 3-i on lanes 8-0. All other lanes read as zero.
- R4: With `size_code` = 01 (half word), an entry takes two reads. Big-endian gives the upper half and then the lower half of the permuted word, both on lanes 35-18. Little-endian gives the lower half and then the upper half, both on lanes 17-0. All other lanes read as zero.
- R5: With `size_code` = 00 (long word), one read delivers the whole permuted word on lanes 35-0.
- R6: A read with `size_code` = 11 copies `mbox_word` to `rd_data` on the next edge. It never pops and never changes the piece position within the current entry, and it does not need `data_avail`.
- R7: `pop` is high in exactly the cycle of the read that takes the last piece of an entry. In the following cycle `data_avail` is 0. In every other case `data_avail` is the registered value of `fifo_has_data`.
- R8: `swap_mode`, `big_endian` and `size_code` are sampled on the first piece of an entry. Changes to them before that entry's last piece have no effect on that entry's pieces (a mailbox code still selects the mailbox).
- R9: A queue read happens only when `port_sel`, `dir_rd`, `rd_en` and `data_avail` are all 1. Without a read, `rd_data` holds its value and `pop` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | Port select, active high |
| dir_rd | input | 1 | 1 selects the read direction |
| rd_en | input | 1 | Read enable |
| swap_mode | input | 2 | Byte permutation select |
| big_endian | input | 1 | 1 big-endian, 0 little-endian piece order |
| size_code | input | 2 | 00 long, 01 half, 10 byte, 11 mailbox |
| fifo_word | input | 36 | Head entry of the storage |
| fifo_has_data | input | 1 | Storage holds at least one entry |
| mbox_word | input | 36 | Mailbox register contents |
| pop | output | 1 | Advance the storage head (last piece read) |
| rd_data | output | 36 | Registered read data |
| data_avail | output | 1 | Registered data-available flag |

## Verification
The properties assume that all control inputs are settled around the rising edge. They also assume the storage behaves consistently: it lowers `fifo_has_data` only after a pop and changes `fifo_word` only on the edge that takes the pop. The bench meets this by changing every input on the falling edge. Its queue model advances its head on the falling edge after a pop was taken, and only appends to the back while non-empty. Mode, endianness and size are randomized on every cycle, including in the middle of an entry, so the latching and mailbox properties see mixed traffic.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_MBOX = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        SW_KEEP = 2'b00,
        SW_REV  = 2'b01,
        SW_HALF = 2'b10,
        SW_PAIR = 2'b11
    } swap_e;

endpackage

// File: rtl/bmr_swap.sv
module bmr_swap #(
    parameter  int BYTE_W  = 9,
    parameter  int N_BYTES = 4,
    localparam int W       = BYTE_W * N_BYTES
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    import bmr_pkg::*;

    // Position j counts from the most significant byte.
    for (genvar j = 0; j < N_BYTES; j++) begin : g_pos
        localparam int SRC_REV  = N_BYTES - 1 - j;
        localparam int SRC_HALF = j ^ (N_BYTES / 2);
        localparam int SRC_PAIR = j ^ 1;
        localparam int DST_HI   = W - 1 - j * BYTE_W;

        logic [BYTE_W-1:0] pick;

        always_comb begin
            unique case (mode)
                SW_REV:  pick = din[W-1-SRC_REV*BYTE_W  -: BYTE_W];
                SW_HALF: pick = din[W-1-SRC_HALF*BYTE_W -: BYTE_W];
                SW_PAIR: pick = din[W-1-SRC_PAIR*BYTE_W -: BYTE_W];
                default: pick = din[DST_HI -: BYTE_W];
            endcase
        end

        assign dout[DST_HI -: BYTE_W] = pick;
    end

endmodule

// File: rtl/bmr_lane_mux.sv
module bmr_lane_mux #(
    parameter  int BYTE_W  = 9,
    parameter  int N_BYTES = 4,
    localparam int W       = BYTE_W * N_BYTES,
    localparam int IDX_W   = $clog2(N_BYTES)
) (
    input  logic [W-1:0]     word,
    input  logic [1:0]       size,
    input  logic             big,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     lanes
);
    import bmr_pkg::*;

    localparam int HALF_W = W / 2;

    logic [IDX_W-1:0]  byte_k;
    logic [BYTE_W-1:0] byte_v;
    logic              take_low;
    logic [HALF_W-1:0] half_v;

    always_comb begin
        // Big-endian walks from the top byte down, little-endian from the bottom up.
        byte_k   = big ? idx : (IDX_W'(N_BYTES - 1) - idx);
        byte_v   = BYTE_W'(word >> ((N_BYTES - 1 - int'(byte_k)) * BYTE_W));
        take_low = big ? idx[0] : ~idx[0];
        half_v   = take_low ? word[HALF_W-1:0] : word[W-1:HALF_W];

        lanes = '0;
        unique case (size)
            SZ_BYTE: begin
                if (big) lanes[W-1 -: BYTE_W]  = byte_v;
                else     lanes[BYTE_W-1:0]     = byte_v;
            end
            SZ_HALF: begin
                if (big) lanes[W-1 -: HALF_W]  = half_v;
                else     lanes[HALF_W-1:0]     = half_v;
            end
            default: lanes = word;
        endcase
    end

endmodule

// File: rtl/bmr_read_port.sv
module bmr_read_port #(
    parameter  int BYTE_W  = 9,
    parameter  int N_BYTES = 4,
    localparam int W       = BYTE_W * N_BYTES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_sel,
    input  logic         dir_rd,
    input  logic         rd_en,
    input  logic [1:0]   swap_mode,
    input  logic         big_endian,
    input  logic [1:0]   size_code,
    input  logic [W-1:0] fifo_word,
    input  logic         fifo_has_data,
    input  logic [W-1:0] mbox_word,
    output logic         pop,
    output logic [W-1:0] rd_data,
    output logic         data_avail
);
    import bmr_pkg::*;

    localparam int IDX_W = $clog2(N_BYTES);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [1:0]       size;
        logic [1:0]       mode;
        logic             big;
        logic             avail;
        logic [W-1:0]     data;
    } state_t;

    state_t s_q, s_d;

    logic         access_d;
    logic         mbox_rd_d;
    logic         fifo_rd_d;
    logic         first_d;
    logic         last_d;
    logic [1:0]   eff_size_d;
    logic [1:0]   eff_mode_d;
    logic         eff_big_d;
    logic [W-1:0] swapped_d;
    logic [W-1:0] lanes_d;

    // Settings in force: live inputs on the first piece, held copies after.
    always_comb begin
        access_d   = port_sel & dir_rd & rd_en;
        mbox_rd_d  = access_d & (size_code == SZ_MBOX);
        fifo_rd_d  = access_d & (size_code != SZ_MBOX) & s_q.avail;
        first_d    = (s_q.idx == '0);
        eff_size_d = first_d ? size_code  : s_q.size;
        eff_mode_d = first_d ? swap_mode  : s_q.mode;
        eff_big_d  = first_d ? big_endian : s_q.big;
    end

    bmr_swap #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_swap (
        .mode (eff_mode_d),
        .din  (fifo_word),
        .dout (swapped_d)
    );

    bmr_lane_mux #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (N_BYTES)
    ) u_lanes (
        .word  (swapped_d),
        .size  (eff_size_d),
        .big   (eff_big_d),
        .idx   (s_q.idx),
        .lanes (lanes_d)
    );

    always_comb begin
        unique case (eff_size_d)
            SZ_BYTE: last_d = (s_q.idx == IDX_W'(N_BYTES - 1));
            SZ_HALF: last_d = (s_q.idx == IDX_W'(1));
            default: last_d = 1'b1;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.avail = fifo_has_data;
        if (mbox_rd_d) begin
            s_d.data = mbox_word;
        end else if (fifo_rd_d) begin
            s_d.data = lanes_d;
            if (first_d) begin
                s_d.size = size_code;
                s_d.mode = swap_mode;
                s_d.big  = big_endian;
            end
            if (last_d) begin
                s_d.idx   = '0;
                s_d.avail = 1'b0;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop        = fifo_rd_d & last_d;
    assign rd_data    = s_q.data;
    assign data_avail = s_q.avail;

endmodule

// File: rtl/bmr_read_port_chk.sv
module bmr_read_port_chk #(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         port_sel,
    input logic         dir_rd,
    input logic         rd_en,
    input logic [1:0]   size_code,
    input logic [W-1:0] mbox_word,
    input logic         pop,
    input logic [W-1:0] rd_data,
    input logic         data_avail
);

    // R7
    pop_then_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !data_avail);

    // R7
    pop_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> data_avail);

    // R9
    pop_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (port_sel && dir_rd && rd_en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_sel && dir_rd && rd_en) |=> $stable(rd_data));

    // R6
    mbox_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sel && dir_rd && rd_en && size_code == 2'b11) |=> rd_data == $past(mbox_word));

    // R6
    mbox_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b11) |-> !pop);

endmodule

bind bmr_read_port bmr_read_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_sel   (port_sel),
    .dir_rd     (dir_rd),
    .rd_en      (rd_en),
    .size_code  (size_code),
    .mbox_word  (mbox_word),
    .pop        (pop),
    .rd_data    (rd_data),
    .data_avail (data_avail)
);

// File: tb/tb_bmr_read_port.sv
`timescale 1ns/1ps
module tb_bmr_read_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        port_sel, dir_rd, rd_en, big_endian, fifo_has_data;
    logic [1:0]  swap_mode, size_code;
    logic [35:0] fifo_word, mbox_word, rd_data;
    logic        pop, data_avail;

    always #2 clk = ~clk;   // 250 MHz

    bmr_read_port dut (
        .clk (clk), .rst_n (rst_n), .port_sel (port_sel), .dir_rd (dir_rd),
        .rd_en (rd_en), .swap_mode (swap_mode), .big_endian (big_endian),
        .size_code (size_code), .fifo_word (fifo_word),
        .fifo_has_data (fifo_has_data), .mbox_word (mbox_word), .pop (pop),
        .rd_data (rd_data), .data_avail (data_avail)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Reference model state
    logic [35:0] mq[$];
    bit          pend_pop  = 0;
    int          m_idx     = 0;
    int          m_size    = 0;
    int          m_mode    = 0;
    bit          m_big     = 0;
    logic [35:0] exp_dout  = '0;
    bit          exp_avail = 0;
    string       exp_tag   = "R1";

    function automatic logic [35:0] swap_ref(input logic [35:0] w, input int mode);
        logic [8:0] a, b, c, d;
        a = w[35:27]; b = w[26:18]; c = w[17:9]; d = w[8:0];
        case (mode)
            0: return {a, b, c, d};
            1: return {d, c, b, a};
            2: return {c, d, a, b};
            default: return {b, a, d, c};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit dr, input bit en, input int mode,
                        input bit big, input int size);
        bit          acc, n_pop, n_avail;
        logic [35:0] n_dout, sw;
        logic [17:0] hv;
        logic [8:0]  bv;
        int          pieces, k;
        string       n_tag;
        @(negedge clk);
        if (pend_pop) begin
            void'(mq.pop_front());
            pend_pop = 0;
        end
        port_sel = s; dir_rd = dr; rd_en = en;
        swap_mode = 2'(mode); big_endian = big; size_code = 2'(size);
        mbox_word = {$urandom(), 4'($urandom())};
        fifo_has_data = (mq.size() != 0);
        fifo_word = (mq.size() != 0) ? mq[0] : '0;

        acc = s & dr & en;
        n_pop = 0; n_avail = fifo_has_data; n_dout = exp_dout; n_tag = "R9";
        if (acc && size == 3) begin
            n_dout = mbox_word; n_tag = "R6";
        end else if (acc && exp_avail) begin
            if (m_idx == 0) begin
                m_size = size; m_mode = mode; m_big = big;
            end
            sw = swap_ref(fifo_word, m_mode);
            case (m_size)
                0: begin n_dout = sw; pieces = 1; n_tag = "R5"; end
                1: begin
                    hv = ((m_big ? m_idx : 1 - m_idx) == 0) ? sw[35:18] : sw[17:0];
                    n_dout = m_big ? {hv, 18'h0} : {18'h0, hv};
                    pieces = 2; n_tag = "R4";
                end
                default: begin
                    k  = m_big ? m_idx : 3 - m_idx;
                    bv = sw[35 - 9*k -: 9];
                    n_dout = m_big ? {bv, 27'h0} : {27'h0, bv};
                    pieces = 4; n_tag = "R3";
                end
            endcase
            if (m_mode != 0) n_tag = {n_tag, ",R2"};
            if (m_idx != 0)  n_tag = {n_tag, ",R8"};
            if (m_idx == pieces - 1) begin
                n_pop = 1; n_avail = 0; m_idx = 0;
            end else begin
                m_idx++;
            end
        end
        #1;
        check(rd_data === exp_dout, exp_tag, "rd_data", rd_data, exp_dout);
        check(data_avail === exp_avail, "R7", "data_avail", 36'(data_avail), 36'(exp_avail));
        check(pop === n_pop, n_pop ? "R7" : "R9", "pop", 36'(pop), 36'(n_pop));
        exp_dout = n_dout; exp_avail = n_avail; exp_tag = n_tag; pend_pop = n_pop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; port_sel = 0; dir_rd = 0; rd_en = 0; swap_mode = 0;
        big_endian = 0; size_code = 0; fifo_word = '0; fifo_has_data = 0;
        mbox_word = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset, even with a pending word and enables up
        fifo_word = 36'hABCDE1234; fifo_has_data = 1; port_sel = 1; dir_rd = 1; rd_en = 1;
        @(posedge clk); #1;
        check(rd_data === '0, "R1", "reset rd_data", rd_data, '0);
        check(data_avail === 1'b0, "R1", "reset data_avail", 36'(data_avail), 36'h0);
        @(negedge clk);
        port_sel = 0; fifo_has_data = 0;
        rst_n = 1;

        // Directed sweep: every permutation, endianness and size (R2..R5)
        for (int mo = 0; mo < 4; mo++)
            for (int bg = 0; bg < 2; bg++)
                for (int sz = 0; sz < 3; sz++) begin
                    mq.push_back({9'(9'h100 + mo*16 + bg*4 + sz), 9'h0A5, 9'h13C, 9'h0F2});
                    for (int r = 0; r < 6; r++) step(1, 1, 1, mo, bg[0], sz);
                end

        // Mailbox in the middle of a byte-mode entry (R6, R8)
        mq.push_back(36'h1_2345_6789);
        step(1, 1, 1, 1, 1, 2);
        step(1, 1, 1, 1, 1, 2);
        step(1, 1, 1, 0, 0, 2);
        step(1, 1, 1, 2, 0, 3);
        step(1, 1, 1, 3, 0, 0);
        step(1, 1, 1, 0, 0, 2);
        step(1, 1, 1, 0, 0, 2);

        // Randomized traffic with mid-entry setting changes and drain windows
        for (int i = 0; i < 4000; i++) begin
            if ((i % 250) > 40 && mq.size() < 3 && $urandom_range(0, 9) < 7)
                mq.push_back({$urandom(), 4'($urandom())});
            step($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3),
                 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 9) == 0) ? 3 : $urandom_range(0, 2));
        end
        step(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule